// File: doc/BRIEF.md
# Microcontroller Reset Sequencer

This block collects every internal reset source of a small microcontroller and turns it into three timed controls: a hold on the CPU and module clocks, the open-drain style external reset pin, and the CPU reset that gates the reset-vector fetch. A low-supply condition forces all three at once. Once the supply recovers, a long oscillator-settling wait runs first. After it the pin is freed, and the CPU is freed later still. Causes raised while the CPU runs (watchdog expiry, an undefined opcode, a forbidden STOP, an opcode fetch from an unmapped address) skip the settling wait. They pull the pin and the CPU into reset at once and release them on the same staggered schedule.

The block contains the free-running watchdog. Software keeps it alive by writing to one fixed address. A four-bit cause register records why the last reset happened. The CPU reads it through `cause_q` and clears it with a read strobe. All inputs are synchronous to the oscillator clock, except `supply_low`, which acts on the state at once.

Top module: `reset_sequencer`

## Requirements
- R1: While `supply_low` is 1, and from the moment it rises, `clk_hold`=1, `rst_pin_n`=0, `cpu_rst`=1 and `cause_q`=4'b0001 (bit 0 = supply, bit 1 = watchdog, bit 2 = illegal opcode, bit 3 = illegal fetch address).
- R2: After `supply_low` falls, `clk_hold` stays 1 and `rst_pin_n` stays 0 for exactly SETTLE_CYC clock edges. The first of these is the first edge with the supply good. `clk_hold` is 0 after that edge.
- R3: After a supply-low reset, `rst_pin_n` becomes 1 exactly PIN_DLY edges after `clk_hold` falls.
- R4: After a supply-low reset, `cpu_rst` becomes 0 exactly CPU_DLY edges after `clk_hold` falls. The pin is never released later than the CPU.
- R5: While the CPU runs, the watchdog makes an internal reset and sets `cause_q`=4'b0010 on the 2**WD_W-th edge after the CPU left reset or after the last watchdog clear.
- R6: A write cycle (`bus_valid`=1, `bus_wr`=1) to address WD_ADDR clears the watchdog. No data value takes part. Writes to other addresses and reads of WD_ADDR do not clear it.
- R7: A pulse on `bad_opc` while the CPU runs makes an internal reset and sets `cause_q`=4'b0100.
- R8: A pulse on `stop_exec` with `stop_ok`=0 acts as an illegal opcode (`cause_q`=4'b0100). With `stop_ok`=1 it has no effect.
- R9: A fetch cycle (`bus_valid`, `bus_fetch`, `bus_unmapped` all 1) while the CPU runs makes an internal reset and sets `cause_q`=4'b1000. A data cycle (`bus_fetch`=0) to an unmapped address does not.
- R10: An internal reset drives `rst_pin_n`=0 and `cpu_rst`=1 right after the edge that takes the cause. `clk_hold` stays 0. The pin is released PIN_DLY edges and the CPU CPU_DLY edges after that edge.
- R11: A newly latched cause replaces all older bits. Causes taken on the same edge are all set.
- R12: A pulse on `cause_rd` clears `cause_q` to 0 at that edge, unless a cause is taken on the same edge. In that case the new cause is shown.
- R13: Internal causes are ignored while `cpu_rst` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| supply_low | input | 1 | Comparator output, 1 while supply is below trip level (asynchronous) |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_fetch | input | 1 | The bus cycle is an opcode fetch |
| bus_wr | input | 1 | The bus cycle is a write |
| bus_unmapped | input | 1 | The bus address hits no mapped resource |
| bus_addr | input | ADDR_W | Bus address |
| bad_opc | input | 1 | Decoder flags an undefined opcode |
| stop_exec | input | 1 | STOP instruction executed |
| stop_ok | input | 1 | Configuration: STOP allowed |
| cause_rd | input | 1 | CPU reads the cause register |
| clk_hold | output | 1 | Hold CPU and module clocks inactive |
| rst_pin_n | output | 1 | External reset pin drive, 0 = driven low |
| cpu_rst | output | 1 | Hold CPU in reset |
| cause_q | output | 4 | Reset cause register |

## Verification
The bench builds the block with SETTLE_CYC=40, PIN_DLY=8, CPU_DLY=16 and WD_W=6. With these values the settling wait and a full watchdog expiry take tens of cycles, not thousands. The bench can therefore count every release edge exactly and run the watchdog to overflow twice, once with non-clearing accesses and once with a clearing write. The ratio of the two release delays matches the default values, so the order of pin and CPU release is exercised as the defaults would exercise it.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
   typedef enum logic [1:0] {PH_DOWN, PH_SETTLE, PH_STAGGER, PH_RUN} phase_e;
   localparam int NCAUSE  = 4;
   localparam int C_SUPPLY = 0;
   localparam int C_WDOG   = 1;
   localparam int C_OPC    = 2;
   localparam int C_FETCH  = 3;
endpackage

// File: rtl/rstseq_wdog.sv
module rstseq_wdog #(
   parameter int WD_W = 18
) (
   input  logic clk,
   input  logic supply_low,
   input  logic run,
   input  logic kick,
   output logic expire
);
   localparam logic [WD_W-1:0] WD_TOP = '1;

   logic [WD_W-1:0] cnt_q;

   always_ff @(posedge clk or posedge supply_low) begin
      if (supply_low)        cnt_q <= '0;
      else if (!run || kick) cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
   end

   assign expire = run && !kick && (cnt_q == WD_TOP);
endmodule

// File: rtl/rstseq_phase.sv
module rstseq_phase
   import rstseq_pkg::*;
#(
   parameter int SETTLE_CYC = 4096,
   parameter int PIN_DLY    = 32,
   parameter int CPU_DLY    = 64
) (
   input  logic clk,
   input  logic supply_low,
   input  logic int_rst,
   output logic clk_hold,
   output logic rst_pin_n,
   output logic cpu_rst,
   output logic run
);
   localparam int CNT_MAX = (SETTLE_CYC > CPU_DLY) ? SETTLE_CYC : CPU_DLY;
   localparam int CW      = $clog2(CNT_MAX + 1);
   localparam logic [CW-1:0] SETTLE_END = CW'(SETTLE_CYC - 1);
   localparam logic [CW-1:0] CPU_END    = CW'(CPU_DLY - 1);
   localparam logic [CW-1:0] PIN_AT     = CW'(PIN_DLY);

   phase_e        ph_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or posedge supply_low) begin
      if (supply_low) begin
         ph_q  <= PH_DOWN;
         cnt_q <= '0;
      end else begin
         unique case (ph_q)
            PH_DOWN: begin
               ph_q  <= PH_SETTLE;
               cnt_q <= CW'(1);
            end
            PH_SETTLE: begin
               if (cnt_q == SETTLE_END) begin
                  ph_q  <= PH_STAGGER;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            PH_STAGGER: begin
               if (cnt_q == CPU_END) begin
                  ph_q  <= PH_RUN;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            PH_RUN: begin
               if (int_rst) begin
                  ph_q  <= PH_STAGGER;
                  cnt_q <= '0;
               end
            end
            default: begin
               ph_q  <= PH_DOWN;
               cnt_q <= '0;
            end
         endcase
      end
   end

   always_comb begin
      clk_hold  = (ph_q == PH_DOWN) || (ph_q == PH_SETTLE);
      run       = (ph_q == PH_RUN);
      cpu_rst   = !run;
      rst_pin_n = run || ((ph_q == PH_STAGGER) && (cnt_q >= PIN_AT));
   end
endmodule

// File: rtl/rstseq_cause.sv
module rstseq_cause
   import rstseq_pkg::*;
(
   input  logic              clk,
   input  logic              supply_low,
   input  logic [NCAUSE-1:0] take,
   input  logic              rd,
   output logic [NCAUSE-1:0] cause_q
);
   logic any_take;
   assign any_take = |take;

   for (genvar i = 0; i < NCAUSE; i++) begin : g_bit
      if (i == C_SUPPLY) begin : g_async
         always_ff @(posedge clk or posedge supply_low) begin
            if (supply_low)          cause_q[i] <= 1'b1;
            else if (any_take || rd) cause_q[i] <= 1'b0;
         end
      end else begin : g_sync
         always_ff @(posedge clk or posedge supply_low) begin
            if (supply_low)    cause_q[i] <= 1'b0;
            else if (any_take) cause_q[i] <= take[i];
            else if (rd)       cause_q[i] <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
   import rstseq_pkg::*;
#(
   parameter int          SETTLE_CYC = 4096,
   parameter int          PIN_DLY    = 32,
   parameter int          CPU_DLY    = 64,
   parameter int          WD_W       = 18,
   parameter int          ADDR_W     = 16,
   parameter logic [15:0] WD_ADDR    = 16'hFFFF
) (
   input  logic              clk,
   input  logic              supply_low,
   input  logic              bus_valid,
   input  logic              bus_fetch,
   input  logic              bus_wr,
   input  logic              bus_unmapped,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bad_opc,
   input  logic              stop_exec,
   input  logic              stop_ok,
   input  logic              cause_rd,
   output logic              clk_hold,
   output logic              rst_pin_n,
   output logic              cpu_rst,
   output logic [NCAUSE-1:0] cause_q
);
   if (SETTLE_CYC < 2)     begin : g_bad_settle $error("SETTLE_CYC must be at least 2"); end
   if (PIN_DLY < 1)        begin : g_bad_pin    $error("PIN_DLY must be at least 1"); end
   if (CPU_DLY <= PIN_DLY) begin : g_bad_cpu    $error("CPU_DLY must exceed PIN_DLY"); end
   if (WD_W < 2)           begin : g_bad_wd     $error("WD_W must be at least 2"); end
   if (ADDR_W > 16)        begin : g_bad_addr   $error("ADDR_W must not exceed 16"); end

   localparam logic [ADDR_W-1:0] KICK_ADDR = WD_ADDR[ADDR_W-1:0];

   logic              run, kick, expire, opc_bad, fetch_bad;
   logic [NCAUSE-1:0] take;

   assign kick      = bus_valid && bus_wr && (bus_addr == KICK_ADDR);
   assign opc_bad   = bad_opc || (stop_exec && !stop_ok);
   assign fetch_bad = bus_valid && bus_fetch && bus_unmapped;

   always_comb begin
      take           = '0;
      take[C_WDOG]   = run && expire;
      take[C_OPC]    = run && opc_bad;
      take[C_FETCH]  = run && fetch_bad;
   end

   rstseq_wdog #(.WD_W(WD_W)) i_wdog (
      .clk(clk), .supply_low(supply_low), .run(run), .kick(kick), .expire(expire)
   );

   rstseq_phase #(.SETTLE_CYC(SETTLE_CYC), .PIN_DLY(PIN_DLY), .CPU_DLY(CPU_DLY)) i_phase (
      .clk(clk), .supply_low(supply_low), .int_rst(|take),
      .clk_hold(clk_hold), .rst_pin_n(rst_pin_n), .cpu_rst(cpu_rst), .run(run)
   );

   rstseq_cause i_cause (
      .clk(clk), .supply_low(supply_low), .take(take), .rd(cause_rd), .cause_q(cause_q)
   );
endmodule

// File: rtl/rstseq_checker.sv
module rstseq_checker
   import rstseq_pkg::*;
(
   input logic              clk,
   input logic              supply_low,
   input logic              clk_hold,
   input logic              rst_pin_n,
   input logic              cpu_rst,
   input logic              cause_rd,
   input logic [NCAUSE-1:0] cause_q
);
   AST_DOWN_FORCES_ALL: assert property (@(posedge clk)
      supply_low |-> (clk_hold && !rst_pin_n && cpu_rst && cause_q == 4'b0001)); // R1

   AST_HOLD_KEEPS_PIN: assert property (@(posedge clk) disable iff (supply_low)
      clk_hold |-> !rst_pin_n); // R2

   AST_PIN_LOW_KEEPS_CPU: assert property (@(posedge clk) disable iff (supply_low)
      !rst_pin_n |-> cpu_rst); // R4

   AST_PIN_FREED_FIRST: assert property (@(posedge clk) disable iff (supply_low)
      $rose(rst_pin_n) |-> cpu_rst); // R3

   AST_INT_NO_HOLD: assert property (@(posedge clk) disable iff (supply_low)
      $fell(rst_pin_n) |-> !clk_hold); // R10

   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (supply_low)
      (cause_rd && cpu_rst) |=> (cause_q == '0)); // R12
endmodule

bind reset_sequencer rstseq_checker i_rstseq_checker (
   .clk(clk), .supply_low(supply_low), .clk_hold(clk_hold), .rst_pin_n(rst_pin_n),
   .cpu_rst(cpu_rst), .cause_rd(cause_rd), .cause_q(cause_q)
);

// File: tb/test_reset_sequencer.sv
module test_reset_sequencer;
   localparam int SC = 40;
   localparam int PD = 8;
   localparam int CD = 16;
   localparam int WW = 6;
   localparam int WD_PERIOD = 1 << WW;

   logic        clk = 1'b0;
   logic        supply_low = 1'b0;
   logic        bus_valid = 1'b0, bus_fetch = 1'b0, bus_wr = 1'b0, bus_unmapped = 1'b0;
   logic [15:0] bus_addr = '0;
   logic        bad_opc = 1'b0, stop_exec = 1'b0, stop_ok = 1'b0, cause_rd = 1'b0;
   logic        clk_hold, rst_pin_n, cpu_rst;
   logic [3:0]  cause_q;

   int n_chk  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   reset_sequencer #(.SETTLE_CYC(SC), .PIN_DLY(PD), .CPU_DLY(CD), .WD_W(WW)) i_reset_sequencer (
      .clk(clk), .supply_low(supply_low), .bus_valid(bus_valid), .bus_fetch(bus_fetch),
      .bus_wr(bus_wr), .bus_unmapped(bus_unmapped), .bus_addr(bus_addr), .bad_opc(bad_opc),
      .stop_exec(stop_exec), .stop_ok(stop_ok), .cause_rd(cause_rd),
      .clk_hold(clk_hold), .rst_pin_n(rst_pin_n), .cpu_rst(cpu_rst), .cause_q(cause_q)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      #2;
   endtask

   task automatic bus_idle();
      bus_valid = 0; bus_fetch = 0; bus_wr = 0; bus_unmapped = 0; bus_addr = '0;
   endtask

   task automatic power_up();
      supply_low = 1'b1;
      tick(2);
      supply_low = 1'b0;
      tick(SC + CD);
   endtask

   task automatic t_supply();
      supply_low = 1'b1;
      #1;
      check("R1 hold", clk_hold, 1);
      check("R1 pin", rst_pin_n, 0);
      check("R1 cpu", cpu_rst, 1);
      check("R1 cause", cause_q, 4'b0001);
      tick(1);
      supply_low = 1'b0;
      tick(SC - 1);
      check("R2 hold kept", clk_hold, 1);
      check("R2 pin low", rst_pin_n, 0);
      tick(1);
      check("R2 hold freed", clk_hold, 0);
      tick(PD - 1);
      check("R3 pin still low", rst_pin_n, 0);
      tick(1);
      check("R3 pin freed", rst_pin_n, 1);
      check("R4 cpu still held", cpu_rst, 1);
      tick(CD - PD - 1);
      check("R4 cpu held", cpu_rst, 1);
      tick(1);
      check("R4 cpu freed", cpu_rst, 0);
      check("R1 cause kept", cause_q, 4'b0001);
      supply_low = 1'b1;
      #1;
      check("R1 brownout pin", rst_pin_n, 0);
      check("R1 brownout hold", clk_hold, 1);
      tick(1);
   endtask

   task automatic t_read();
      power_up();
      cause_rd = 1; tick(1); cause_rd = 0;
      check("R12 read clears", cause_q, 0);
   endtask

   task automatic t_opcode();
      power_up();
      bad_opc = 1; tick(1); bad_opc = 0;
      check("R7 cpu", cpu_rst, 1);
      check("R10 pin low", rst_pin_n, 0);
      check("R10 no hold", clk_hold, 0);
      check("R11 cause", cause_q, 4'b0100);
      tick(PD - 1);
      check("R10 pin held", rst_pin_n, 0);
      tick(1);
      check("R10 pin freed", rst_pin_n, 1);
      bus_valid = 1; bus_fetch = 1; bus_unmapped = 1; tick(1); bus_idle();
      check("R13 ignored", cause_q, 4'b0100);
      tick(CD - PD - 2);
      check("R10 cpu held", cpu_rst, 1);
      tick(1);
      check("R10 cpu freed", cpu_rst, 0);
      bad_opc = 1; cause_rd = 1; tick(1); bad_opc = 0; cause_rd = 0;
      check("R12 cause wins", cause_q, 4'b0100);
   endtask

   task automatic t_stop();
      power_up();
      stop_ok = 1; stop_exec = 1; tick(1); stop_exec = 0;
      check("R8 allowed cpu", cpu_rst, 0);
      check("R8 allowed cause", cause_q, 4'b0001);
      stop_ok = 0; stop_exec = 1; tick(1); stop_exec = 0;
      check("R8 forbidden cpu", cpu_rst, 1);
      check("R8 forbidden cause", cause_q, 4'b0100);
   endtask

   task automatic t_fetch();
      power_up();
      bus_valid = 1; bus_unmapped = 1; tick(1); bus_idle();
      check("R9 data cpu", cpu_rst, 0);
      check("R9 data cause", cause_q, 4'b0001);
      bus_valid = 1; bus_fetch = 1; bus_unmapped = 1; tick(1); bus_idle();
      check("R9 fetch cpu", cpu_rst, 1);
      check("R9 fetch cause", cause_q, 4'b1000);
   endtask

   task automatic t_both();
      power_up();
      bad_opc = 1; bus_valid = 1; bus_fetch = 1; bus_unmapped = 1; tick(1);
      bad_opc = 0; bus_idle();
      check("R11 both set", cause_q, 4'b1100);
   endtask

   task automatic t_wdog();
      power_up();
      tick(20);
      bus_valid = 1; bus_wr = 1; bus_addr = 16'hFFFE; tick(1);
      bus_wr = 0; bus_addr = 16'hFFFF; tick(1); bus_idle();
      tick(WD_PERIOD - 23);
      check("R6 no clear cpu", cpu_rst, 0);
      tick(1);
      check("R5 expire cpu", cpu_rst, 1);
      check("R5 cause", cause_q, 4'b0010);
      power_up();
      tick(30);
      bus_valid = 1; bus_wr = 1; bus_addr = 16'hFFFF; tick(1); bus_idle();
      tick(WD_PERIOD - 1);
      check("R6 cleared cpu", cpu_rst, 0);
      tick(1);
      check("R6 expire later", cpu_rst, 1);
      check("R5 cause again", cause_q, 4'b0010);
   endtask

   initial begin
      #1 supply_low = 1'b1;
      tick(1);
      t_supply();
      t_read();
      t_opcode();
      t_stop();
      t_fetch();
      t_both();
      t_wdog();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule